// File: doc/BRIEF.md
# Keyed System Control Register Bank

This block is the register file that sits beside a processor module and holds its board-level control state. Software reaches it over a simple word-addressed register bus. A request is a single-cycle strobe with a write flag, a byte address and 32 bits of write data. Read data comes back on the following clock edge.

The bank provides the following:
- two fixed identification and status words;
- a 16-bit unlock key that guards the two clock-oscillator registers;
- a control register. Its bit 0 drives an LED, its bit 2 drives a memory-remap output, and its bit 3 is a write-only reset request;
- two flag registers, each with one address that sets bits and another that clears them;
- a free-running reference counter that advances on a 24 MHz clock-enable strobe;
- a read-only byte table that describes the fitted memory.

The memory-setup and init registers simply store what software writes. A memory-size parameter, given in MB, folds a size code into the reset value of the memory-setup register.

Top module: `sysctl_keyed_bank`

## Requirements
- R1: Word 0 reads 0x411A3001, word 4 reads 0x00100000 and word 1 reads zero. Any word offset that is not decoded reads zero, and a write to it changes no readable register.
- R2: A write to word 5 (the key register) keeps bits [15:0] of the data. A read returns the kept value, and bit 16 is also set when that value equals 0xA05F.
- R3: Word 2 (oscillator) and word 7 (auxiliary oscillator) accept a write only while the key register holds 0xA05F. Otherwise the write is dropped.
- R4: Word 3 (control) stores data bits 0 and 2 only. A write with bit 3 set drives `reset_req` high for exactly the cycle after the write. Bit 3 and all other unstored bits read as 0.
- R5: `led_on` follows control bit 0. `boot_unmap` follows control bit 2: low means boot flash is mapped at address zero, and high means it is unmapped.
- R6: Word 12 reads the flags register. A write to word 12 ORs the data into it, and a write to word 13 clears each bit that is 1 in the data.
- R7: Word 14 reads the non-volatile flags register. Words 14 and 15 set and clear it in the same way as R6.
- R8: Word 10 reads the reference counter. The counter starts at 0 after reset, adds 1 (modulo 2^32) on each cycle where `ref_tick` is high, and holds otherwise.
- R9: Byte offsets 0x100..0x17C return table entry (offset/4), zero-extended. Entries are 0x40:0x80, 0x41:0x08, 0x42:0x04, 0x43:0x0B, 0x44:0x09, 0x45:0x01, 0x46:min(MEM_MB/4,255), and every other entry is 0. Offsets 0x180..0x1FC read zero.
- R10: After reset, word 2 reads 0x01000048, word 7 reads 0x0007FEFF, word 9 reads 0x00000112, and the control, flags, key and counter registers read zero. Words 8 and 9 store a full 32-bit write.
- R11: Word 8 resets to 0x00011122 ORed with a size code: 0x10 if MEM_MB≥256, 0x0C if ≥128, 0x08 if ≥64, 0x04 if ≥32, and 0 below 32.
- R12: A read strobe places its data on `bus_rdata` at the next clock edge. In any cycle after an edge with no read strobe, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | 24 MHz clock-enable strobe for the reference counter |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle system reset request |
| boot_unmap | output | 1 | High removes boot flash from address zero |
| led_on | output | 1 | Status LED drive |

## Verification
Some behaviours are checked by assertions on every cycle:
- a locked oscillator register never changes;
- set writes leave the written bits at one, and clear writes leave them at zero;
- the counter moves by exactly one on a tick and stays still without one;
- `reset_req` is only ever the echo of a control write that had bit 3 set;
- read data falls to zero after an idle edge;
- the key read-back flag matches the unlock state.

Other behaviours need the bench's scenarios to show them:
- the absolute values: identification words, reset values, the size code and the table contents;
- that unmapped writes are harmless;
- the exact cycle of the reset pulse.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   // word indices of the decoded registers
   localparam int unsigned W_IDENT   = 0;
   localparam int unsigned W_PROC    = 1;
   localparam int unsigned W_OSC     = 2;
   localparam int unsigned W_CTRL    = 3;
   localparam int unsigned W_STATUS  = 4;
   localparam int unsigned W_KEY     = 5;
   localparam int unsigned W_AUXOSC  = 7;
   localparam int unsigned W_MEMSET  = 8;
   localparam int unsigned W_INIT    = 9;
   localparam int unsigned W_REFCNT  = 10;
   localparam int unsigned W_FLG_SET = 12;
   localparam int unsigned W_FLG_CLR = 13;
   localparam int unsigned W_NVF_SET = 14;
   localparam int unsigned W_NVF_CLR = 15;

   // control register bit positions (software-visible, decoded by neighbours)
   localparam int unsigned CB_LED   = 0;
   localparam int unsigned CB_REMAP = 2;
   localparam int unsigned CB_RESET = 3;

   localparam logic [31:0] IDENT_WORD  = 32'h411A_3001;
   localparam logic [31:0] STATUS_WORD = 32'h0010_0000;
   localparam logic [15:0] UNLOCK_KEY  = 16'hA05F;

   localparam logic [31:0] OSC_RST    = 32'h0100_0048;
   localparam logic [31:0] AUXOSC_RST = 32'h0007_FEFF;
   localparam logic [31:0] MEMSET_RST = 32'h0001_1122;
   localparam logic [31:0] INIT_RST   = 32'h0000_0112;

   function automatic logic [31:0] size_code(input int unsigned mb);
      if (mb >= 256)      size_code = 32'h10;
      else if (mb >= 128) size_code = 32'h0C;
      else if (mb >= 64)  size_code = 32'h08;
      else if (mb >= 32)  size_code = 32'h04;
      else                size_code = 32'h00;
   endfunction
endpackage

// File: rtl/sysctl_key_lock.sv
module sysctl_key_lock #(
   parameter int unsigned        KEY_W = 16,
   parameter logic [KEY_W-1:0]   KEY   = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [KEY_W-1:0] wdata,
   output logic [KEY_W-1:0] key_q,
   output logic             unlocked
);
   if (KEY_W < 1 || KEY_W > 31) begin : g_bad_width
      $error("sysctl_key_lock: KEY_W must be 1..31");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  key_q <= '0;
      else if (we) key_q <= wdata;
   end

   assign unlocked = (key_q == KEY);

   a_r2_key_stored: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> key_q == $past(wdata));
   a_r2_key_held: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(key_q));
endmodule

// File: rtl/sysctl_flag_pair.sv
module sysctl_flag_pair #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_width
      $error("sysctl_flag_pair: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (set_we) q <= q | wdata;
      else if (clr_we) q <= q & ~wdata;
   end

   a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> (q & $past(wdata)) == $past(wdata));
   a_r6_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> (q & $past(wdata)) == '0);
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(q));
endmodule

// File: rtl/sysctl_refcount.sv
module sysctl_refcount #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("sysctl_refcount: CNT_W must be 2..32");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (tick) count <= count + 1'b1;
   end

   a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> count == $past(count) + 1'b1);
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));
endmodule

// File: rtl/sysctl_geom_rom.sv
module sysctl_geom_rom #(
   parameter int unsigned MEM_MB = 128,
   parameter int unsigned IDX_W  = 7
) (
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       entry
);
   localparam int unsigned DENS_RAW = MEM_MB / 4;
   localparam logic [7:0]  DENSITY  = (DENS_RAW > 255) ? 8'hFF : 8'(DENS_RAW);

   if (IDX_W != 7) begin : g_bad_idx
      $error("sysctl_geom_rom: table is 128 entries, IDX_W must be 7");
   end

   always_comb begin
      unique case (idx)
         7'h40:   entry = 8'h80;
         7'h41:   entry = 8'h08;
         7'h42:   entry = 8'h04;
         7'h43:   entry = 8'h0B;
         7'h44:   entry = 8'h09;
         7'h45:   entry = 8'h01;
         7'h46:   entry = DENSITY;
         default: entry = 8'h00;
      endcase
   end
endmodule

// File: rtl/sysctl_keyed_bank.sv
module sysctl_keyed_bank
   import sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned MEM_MB = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              reset_req,
   output logic              boot_unmap,
   output logic              led_on
);
   localparam int unsigned WIDX_W  = ADDR_W - 2;
   localparam int unsigned KEY_W   = 16;
   localparam int unsigned N_GATED = 2;
   localparam logic [31:0] MEMSET_INIT = MEMSET_RST | size_code(MEM_MB);

   if (ADDR_W < 10 || ADDR_W > 32) begin : g_bad_addr
      $error("sysctl_keyed_bank: ADDR_W must be 10..32");
   end

   // ---------------- decode ----------------
   logic [WIDX_W-1:0] widx;
   logic              wr_stb, rd_stb, in_table_zone, table_live;
   assign widx          = bus_addr[ADDR_W-1:2];
   assign wr_stb        = bus_sel &&  bus_wr;
   assign rd_stb        = bus_sel && !bus_wr;
   assign in_table_zone = (widx >> 6) == WIDX_W'(1);
   assign table_live    = in_table_zone && !widx[5];

   function automatic logic hit(input logic [WIDX_W-1:0] w, input int unsigned n);
      hit = (w == WIDX_W'(n));
   endfunction

   logic key_we, ctrl_we, memset_we, init_we;
   logic flg_set, flg_clr, nvf_set, nvf_clr;
   logic [N_GATED-1:0] gated_we;
   assign key_we      = wr_stb && hit(widx, W_KEY);
   assign ctrl_we     = wr_stb && hit(widx, W_CTRL);
   assign memset_we   = wr_stb && hit(widx, W_MEMSET);
   assign init_we     = wr_stb && hit(widx, W_INIT);
   assign flg_set     = wr_stb && hit(widx, W_FLG_SET);
   assign flg_clr     = wr_stb && hit(widx, W_FLG_CLR);
   assign nvf_set     = wr_stb && hit(widx, W_NVF_SET);
   assign nvf_clr     = wr_stb && hit(widx, W_NVF_CLR);
   assign gated_we[0] = wr_stb && hit(widx, W_OSC);
   assign gated_we[1] = wr_stb && hit(widx, W_AUXOSC);

   // ---------------- key and gated oscillators ----------------
   logic [KEY_W-1:0] key_q;
   logic             unlocked;

   sysctl_key_lock #(.KEY_W(KEY_W), .KEY(UNLOCK_KEY)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (key_we),
      .wdata    (bus_wdata[KEY_W-1:0]),
      .key_q    (key_q),
      .unlocked (unlocked)
   );

   logic [31:0] gated_q [N_GATED];

   for (genvar g = 0; g < N_GATED; g++) begin : g_gated
      localparam logic [31:0] RST_VAL = (g == 0) ? OSC_RST : AUXOSC_RST;
      always_ff @(posedge clk) begin
         if (!rst_n)                       gated_q[g] <= RST_VAL;
         else if (gated_we[g] && unlocked) gated_q[g] <= bus_wdata;
      end
      a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !unlocked |=> $stable(gated_q[g]));
   end

   // ---------------- control ----------------
   logic ctrl_led_q, ctrl_remap_q, rst_req_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_led_q   <= 1'b0;
         ctrl_remap_q <= 1'b0;
         rst_req_q    <= 1'b0;
      end else begin
         rst_req_q <= ctrl_we && bus_wdata[CB_RESET];
         if (ctrl_we) begin
            ctrl_led_q   <= bus_wdata[CB_LED];
            ctrl_remap_q <= bus_wdata[CB_REMAP];
         end
      end
   end
   assign reset_req  = rst_req_q;
   assign boot_unmap = ctrl_remap_q;
   assign led_on     = ctrl_led_q;

   a_r4_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $past(ctrl_we && bus_wdata[CB_RESET]));
   a_r5_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_we |=> $stable(boot_unmap) && $stable(led_on));

   // ---------------- plain storage ----------------
   logic [31:0] memset_q, init_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         memset_q <= MEMSET_INIT;
         init_q   <= INIT_RST;
      end else begin
         if (memset_we) memset_q <= bus_wdata;
         if (init_we)   init_q   <= bus_wdata;
      end
   end

   // ---------------- flags ----------------
   logic [31:0] flags_q, nvflags_q;

   sysctl_flag_pair #(.W(32)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (flg_set),
      .clr_we (flg_clr),
      .wdata  (bus_wdata),
      .q      (flags_q)
   );

   sysctl_flag_pair #(.W(32)) u_nvflags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (nvf_set),
      .clr_we (nvf_clr),
      .wdata  (bus_wdata),
      .q      (nvflags_q)
   );

   // ---------------- reference counter ----------------
   logic [CNT_W-1:0] ref_count;

   sysctl_refcount #(.CNT_W(CNT_W)) u_refcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (ref_tick),
      .count (ref_count)
   );

   // ---------------- geometry table ----------------
   logic [7:0] geom_byte;

   sysctl_geom_rom #(.MEM_MB(MEM_MB), .IDX_W(7)) u_geom (
      .idx   (widx[6:0]),
      .entry (geom_byte)
   );

   // ---------------- read path ----------------
   logic [31:0] rd_next;
   always_comb begin
      rd_next = '0;
      if (in_table_zone) begin
         if (table_live) rd_next = {24'h0, geom_byte};
      end else if (hit(widx, W_IDENT))   rd_next = IDENT_WORD;
      else if (hit(widx, W_OSC))         rd_next = gated_q[0];
      else if (hit(widx, W_CTRL))        rd_next = 32'(ctrl_remap_q) << CB_REMAP
                                                 | 32'(ctrl_led_q)   << CB_LED;
      else if (hit(widx, W_STATUS))      rd_next = STATUS_WORD;
      else if (hit(widx, W_KEY))         rd_next = {15'h0, unlocked, key_q};
      else if (hit(widx, W_AUXOSC))      rd_next = gated_q[1];
      else if (hit(widx, W_MEMSET))      rd_next = memset_q;
      else if (hit(widx, W_INIT))        rd_next = init_q;
      else if (hit(widx, W_REFCNT))      rd_next = 32'(ref_count);
      else if (hit(widx, W_FLG_SET))     rd_next = flags_q;
      else if (hit(widx, W_NVF_SET))     rd_next = nvflags_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_stb) bus_rdata <= rd_next;
      else             bus_rdata <= '0;
   end

   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> bus_rdata == '0);
   a_r2_unlock_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && hit(widx, W_KEY)) |=> bus_rdata[16] == $past(unlocked));
endmodule

// File: tb/sysctl_keyed_bank_tb.sv
`timescale 1ns/1ps
module sysctl_keyed_bank_tb;
   localparam int unsigned ADDR_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ref_tick = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              reset_req, boot_unmap, led_on;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   sysctl_keyed_bank #(.ADDR_W(ADDR_W), .CNT_W(32), .MEM_MB(128)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_tick   (ref_tick),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .reset_req  (reset_req),
      .boot_unmap (boot_unmap),
      .led_on     (led_on)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input int unsigned addr, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int unsigned addr, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(addr);
      @(posedge clk); #1;
      d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int unsigned addr, input logic [31:0] exp);
      logic [31:0] v;
      bus_read(addr, v);
      chk(req, v, exp);
   endtask

   task automatic t_reset;
      chk("R12 rdata after reset", bus_rdata, 32'h0);
      chk("R5 outputs after reset", {29'h0, reset_req, boot_unmap, led_on}, 32'h0);
      rd_chk("R10 osc reset",    2*4,  32'h0100_0048);
      rd_chk("R10 auxosc reset", 7*4,  32'h0007_FEFF);
      rd_chk("R10 init reset",   9*4,  32'h0000_0112);
      rd_chk("R11 memset reset", 8*4,  32'h0001_112E);
      rd_chk("R10 ctrl reset",   3*4,  32'h0);
      rd_chk("R10 key reset",    5*4,  32'h0);
      rd_chk("R10 flags reset",  12*4, 32'h0);
      rd_chk("R8 counter reset", 10*4, 32'h0);
   endtask

   task automatic t_ident;
      rd_chk("R1 ident word", 0,   32'h411A_3001);
      rd_chk("R1 status word", 16, 32'h0010_0000);
      rd_chk("R1 word1 zero", 4,   32'h0);
      bus_write(6*4, 32'hFFFF_FFFF);
      rd_chk("R1 unmapped word6 ignores write", 6*4, 32'h0);
      bus_write(1*4, 32'h1234_5678);
      rd_chk("R1 word1 ignores write", 4, 32'h0);
      bus_write(40*4, 32'hDEAD_BEEF);
      rd_chk("R1 unmapped word40 zero", 40*4, 32'h0);
      rd_chk("R1 init untouched by unmapped writes", 9*4, 32'h0000_0112);
   endtask

   task automatic t_lock;
      bus_write(5*4, 32'hFFFF_1234);
      rd_chk("R2 key keeps low 16 bits", 5*4, 32'h0000_1234);
      bus_write(5*4, 32'h0000_A05F);
      rd_chk("R2 unlocked readback", 5*4, 32'h0001_A05F);
      bus_write(5*4, 32'h0000_A05E);
      rd_chk("R2 near key no flag", 5*4, 32'h0000_A05E);
   endtask

   task automatic t_osc_gate;
      bus_write(5*4, 32'h0);
      bus_write(2*4, 32'hAAAA_5555);
      bus_write(7*4, 32'h1111_2222);
      rd_chk("R3 locked osc drop",    2*4, 32'h0100_0048);
      rd_chk("R3 locked auxosc drop", 7*4, 32'h0007_FEFF);
      bus_write(5*4, 32'hA05F);
      bus_write(2*4, 32'hAAAA_5555);
      bus_write(7*4, 32'h1111_2222);
      rd_chk("R3 unlocked osc write",    2*4, 32'hAAAA_5555);
      rd_chk("R3 unlocked auxosc write", 7*4, 32'h1111_2222);
      bus_write(5*4, 32'h0);
      bus_write(2*4, 32'h0);
      rd_chk("R3 relocked osc drop", 2*4, 32'hAAAA_5555);
   endtask

   task automatic t_ctrl;
      logic seen;
      bus_write(3*4, 32'hFFFF_FFF7);
      rd_chk("R4 ctrl stores bits 0 and 2", 3*4, 32'h5);
      chk("R5 led and unmap set", {30'h0, boot_unmap, led_on}, 32'h3);
      bus_write(3*4, 32'h1);
      chk("R5 unmap cleared led kept", {30'h0, boot_unmap, led_on}, 32'h1);
      // reset pulse timing
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(3*4); bus_wdata = 32'h8;
      chk("R4 no pulse before edge", {31'h0, reset_req}, 32'h0);
      @(posedge clk); #1;
      seen = reset_req;
      chk("R4 pulse after write", {31'h0, seen}, 32'h1);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      @(posedge clk); #1;
      chk("R4 pulse one cycle", {31'h0, reset_req}, 32'h0);
      rd_chk("R4 reset bit reads zero", 3*4, 32'h0);
   endtask

   task automatic t_flags;
      bus_write(12*4, 32'h0000_00F0);
      bus_write(12*4, 32'h0F00_0001);
      rd_chk("R6 set ORs", 12*4, 32'h0F00_00F1);
      bus_write(13*4, 32'h0300_0030);
      rd_chk("R6 clear masks", 12*4, 32'h0C00_00C1);
      rd_chk("R6 clear word reads zero", 13*4, 32'h0);
      bus_write(14*4, 32'h8000_0003);
      bus_write(15*4, 32'h0000_0001);
      rd_chk("R7 nv flags set clear", 14*4, 32'h8000_0002);
      rd_chk("R7 flags independent", 12*4, 32'h0C00_00C1);
   endtask

   task automatic t_counter;
      logic [31:0] c0, c1;
      bus_read(10*4, c0);
      for (int i = 0; i < 37; i++) begin
         @(negedge clk); ref_tick = 1'b1;
         @(negedge clk); ref_tick = 1'b0;
         @(negedge clk);
      end
      bus_read(10*4, c1);
      chk("R8 counter advances per tick", c1 - c0, 32'd37);
      repeat (10) @(negedge clk);
      rd_chk("R8 counter holds without tick", 10*4, c1);
   endtask

   task automatic t_table;
      rd_chk("R9 entry 0x40", 32'h100, 32'h80);
      rd_chk("R9 entry 0x41", 32'h104, 32'h08);
      rd_chk("R9 entry 0x43", 32'h10C, 32'h0B);
      rd_chk("R9 entry 0x45", 32'h114, 32'h01);
      rd_chk("R9 density entry", 32'h118, 32'h20);
      rd_chk("R9 entry 0x47 zero", 32'h11C, 32'h0);
      rd_chk("R9 last live zero", 32'h17C, 32'h0);
      rd_chk("R9 dead zone start", 32'h180, 32'h0);
      rd_chk("R9 dead zone end", 32'h1FC, 32'h0);
      bus_write(32'h100, 32'hFFFF_FFFF);
      rd_chk("R9 table read only", 32'h100, 32'h80);
   endtask

   task automatic t_latency;
      logic [31:0] v;
      bus_read(8*4, v);
      chk("R12 data on next edge", v, 32'h0001_112E);
      @(posedge clk); #1;
      chk("R12 zero after idle edge", bus_rdata, 32'h0);
      bus_write(8*4, 32'hCAFE_0001);
      rd_chk("R10 memset full write", 8*4, 32'hCAFE_0001);
      @(posedge clk); #1;
      chk("R12 zero after write edge", bus_rdata, 32'h0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ident();
      t_lock();
      t_osc_gate();
      t_ctrl();
      t_flags();
      t_counter();
      t_table();
      t_latency();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule